// File: doc/BRIEF.md
# Length-Framed Packet Receive Deframer

This block sits behind a demodulator that delivers one byte at a time with a valid strobe. It watches for a start-of-packet event, takes the first byte after it as the packet length, and stores up to sixteen payload bytes in a receive buffer. After the payload it takes two trailing check bytes. When the last of them arrives, it reports end of packet and whether the CRC16 it computed matches them.

Start of packet has two sources, chosen by a framing-enable control. With framing on, the start marker detector must report a hit on two consecutive cycles. With framing off, the raw correlator must report hits on two consecutive cycles. A valid packet can raise a one-cycle request to send an acknowledge, if auto-acknowledge is enabled. The downstream logic drains the buffer through a simple read port that has registered data.

Top module: `pkt_rx_deframer`

## Requirements
- R1: With `frame_en`=1, `mark_hit` high on two consecutive cycles while idle starts a packet, and `busy` reads 1 from the following cycle. `corr_hit` has no effect in this mode.
- R2: With `frame_en`=0, `corr_hit` high on two consecutive cycles while idle starts a packet. `mark_hit` has no effect in this mode.
- R3: The first byte accepted (`byte_vld`=1) after the start is the length N. Then come N payload bytes, then two CRC bytes, high byte first. In the cycle after the second CRC byte is accepted, `pkt_done` pulses for one cycle and `busy` returns to 0. N=0 goes straight to the CRC bytes.
- R4: The CRC is CRC16 with polynomial 0x1021 and seed 0x0000, processed MSB first, over the length byte and all N payload bytes. `crc_good` pulses with `pkt_done` on a match and `crc_bad` pulses with it otherwise.
- R5: The first min(N,16) payload bytes are stored in arrival order in a 16-entry buffer, which is emptied when a packet starts. A read with `rd_en`=1 while `rd_empty`=0 presents the oldest byte on `rd_data` in the following cycle.
- R6: A length above 16 sets `len_ovf` from the cycle after the length byte until the next packet start. Payload bytes beyond 16 are dropped, but they are still counted and still enter the CRC.
- R7: `ack_req` pulses together with `crc_good` when `auto_ack_en`=1. It never pulses on a bad CRC or when `auto_ack_en`=0.
- R8: A start event while `busy`=1 is ignored. `abort_in`=1 returns the block to idle in the next cycle, and the aborted packet gives no `pkt_done`.
- R9: A read while `rd_empty`=1 leaves `rd_data` unchanged and sets `underflow`, which stays at 1 until reset.
- R10: After reset: `busy`=0, `rd_empty`=1, `rd_data`=0, `underflow`=0, `len_ovf`=0, and all pulse outputs are 0.
- R11: `byte_vld` while idle has no effect: `busy` stays 0 and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Demodulated byte strobe |
| byte_in | input | 8 | Demodulated byte |
| mark_hit | input | 1 | Start marker symbol detected |
| corr_hit | input | 1 | Raw correlator hit |
| frame_en | input | 1 | 1: marker start, 0: correlator start |
| auto_ack_en | input | 1 | Enable acknowledge request on good packets |
| abort_in | input | 1 | Force return to idle |
| rd_en | input | 1 | Buffer read request |
| rd_data | output | 8 | Registered buffer read data |
| rd_empty | output | 1 | Buffer holds no bytes |
| underflow | output | 1 | Sticky empty-read flag |
| busy | output | 1 | Packet in progress |
| pkt_done | output | 1 | End-of-packet pulse |
| crc_good | output | 1 | CRC match pulse |
| crc_bad | output | 1 | CRC mismatch pulse |
| ack_req | output | 1 | Acknowledge request pulse |
| len_ovf | output | 1 | Length exceeded buffer size |

## Verification
A wrong byte count or a wrong state in the packet sequencer shows on the ports as `busy` falling or `pkt_done` arriving a cycle early or late. The reference model compares every cycle, so such a fault is reported in the cycle it appears. A fault in the CRC register or in the buffer pointers stays hidden until one of two events. The first is the end-of-packet verdict, which can flag the wrong polarity of `crc_good` and `crc_bad`. The second is a read of the buffer, which can return a misordered byte or a wrong `rd_empty`. Packets with lengths of 0, within the buffer size, exactly 16 and above 16 are used so that each counter limit is crossed.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'h0000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN,
    ST_BODY,
    ST_CHI,
    ST_CLO
  } rx_state_t;

  function automatic logic [15:0] crc16_next(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rx_start_detect.sv
module rx_start_detect (
  input  logic clk,
  input  logic rst,
  input  logic frame_en,
  input  logic mark_hit,
  input  logic corr_hit,
  output logic sop
);
  logic mark_q, corr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_q <= 1'b0;
      corr_q <= 1'b0;
    end else begin
      mark_q <= mark_hit;
      corr_q <= corr_hit;
    end
  end

  assign sop = frame_en ? (mark_hit & mark_q) : (corr_hit & corr_q);

  // R1: a framed start needs a marker hit in the previous cycle
  p_framed_pair_r1: assert property (@(posedge clk) disable iff (rst)
    (sop && frame_en) |-> $past(mark_hit));
  // R2: an unframed start needs a correlator hit in the previous cycle
  p_unframed_pair_r2: assert property (@(posedge clk) disable iff (rst)
    (sop && !frame_en) |-> $past(corr_hit));
endmodule

// File: rtl/rx_crc16.sv
module rx_crc16
  import pkt_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc <= CRC_SEED;
    else if (en)    crc <= crc16_next(crc, din);
  end
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          underflow
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic          do_wr, do_rd;

  assign empty = (cnt == '0);
  assign do_wr = wr_en && (cnt != FULL) && !clr;
  assign do_rd = rd_en && !empty && !clr;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (do_rd) begin
      rd_data <= mem[rptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) underflow <= 1'b0;
    else if (rd_en && empty && !clr) underflow <= 1'b1;
  end

  // R5: the writer never offers a byte to a full buffer
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (cnt != FULL));
  // R9: underflow is sticky
  p_underflow_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);
  // R9: an empty read leaves the data register alone
  p_empty_read_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> $stable(rd_data));
endmodule

// File: rtl/pkt_rx_deframer.sv
module pkt_rx_deframer
  import pkt_rx_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int LEN_W     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       mark_hit,
  input  logic       corr_hit,
  input  logic       frame_en,
  input  logic       auto_ack_en,
  input  logic       abort_in,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_empty,
  output logic       underflow,
  output logic       busy,
  output logic       pkt_done,
  output logic       crc_good,
  output logic       crc_bad,
  output logic       ack_req,
  output logic       len_ovf
);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(BUF_DEPTH);

  rx_state_t        state;
  logic [LEN_W-1:0] len_q, got_q;
  logic [7:0]       hi_q;
  logic [15:0]      crc_val;
  logic             sop_det, sop_ok, take, crc_en, wr_en;

  rx_start_detect i_start (
    .clk(clk), .rst(rst), .frame_en(frame_en),
    .mark_hit(mark_hit), .corr_hit(corr_hit), .sop(sop_det)
  );

  assign sop_ok = sop_det && (state == ST_IDLE) && !abort_in;
  assign take   = byte_vld && !abort_in;
  assign crc_en = take && ((state == ST_LEN) || (state == ST_BODY));
  assign wr_en  = take && (state == ST_BODY) && (got_q < DEPTH_L);

  rx_crc16 i_crc (
    .clk(clk), .rst(rst), .clr(sop_ok), .en(crc_en),
    .din(byte_in), .crc(crc_val)
  );

  rx_buffer #(.DEPTH(BUF_DEPTH), .DW(8)) i_buf (
    .clk(clk), .rst(rst), .clr(sop_ok), .wr_en(wr_en), .wr_data(byte_in),
    .rd_en(rd_en), .rd_data(rd_data), .empty(rd_empty), .underflow(underflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      len_q    <= '0;
      got_q    <= '0;
      hi_q     <= '0;
      pkt_done <= 1'b0;
      crc_good <= 1'b0;
      crc_bad  <= 1'b0;
      ack_req  <= 1'b0;
      len_ovf  <= 1'b0;
    end else begin
      pkt_done <= 1'b0;
      crc_good <= 1'b0;
      crc_bad  <= 1'b0;
      ack_req  <= 1'b0;
      if (abort_in) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (sop_det) begin
            state   <= ST_LEN;
            len_ovf <= 1'b0;
          end
          ST_LEN: if (byte_vld) begin
            len_q   <= byte_in;
            got_q   <= '0;
            len_ovf <= (byte_in > DEPTH_L);
            state   <= (byte_in == '0) ? ST_CHI : ST_BODY;
          end
          ST_BODY: if (byte_vld) begin
            got_q <= got_q + 1'b1;
            if (got_q == len_q - 1'b1) state <= ST_CHI;
          end
          ST_CHI: if (byte_vld) begin
            hi_q  <= byte_in;
            state <= ST_CLO;
          end
          ST_CLO: if (byte_vld) begin
            pkt_done <= 1'b1;
            crc_good <= ({hi_q, byte_in} == crc_val);
            crc_bad  <= ({hi_q, byte_in} != crc_val);
            ack_req  <= ({hi_q, byte_in} == crc_val) && auto_ack_en;
            state    <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy = (state != ST_IDLE);

  // R4: every end of packet carries exactly one verdict
  p_one_verdict_r4: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> (crc_good != crc_bad));
  // R7: acknowledge only with a good CRC
  p_ack_good_only_r7: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> crc_good);
  // R3: end of packet is a single-cycle pulse
  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !pkt_done);
  // R8: with no byte and no abort, a packet in progress stays in progress
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !abort_in && !byte_vld) |=> busy);
  // R8: abort always returns to idle
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (rst)
    abort_in |=> !busy);
  // R6: an oversize length raises the overflow flag
  p_long_len_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LEN && byte_vld && !abort_in && byte_in > DEPTH_L) |=> len_ovf);
endmodule

// File: tb/test_pkt_rx_deframer.sv
module test_pkt_rx_deframer;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_vld = 0, mark_hit = 0, corr_hit = 0, frame_en = 1;
  logic auto_ack_en = 0, abort_in = 0, rd_en = 0;
  logic [7:0] byte_in = 0;
  logic [7:0] rd_data;
  logic rd_empty, underflow, busy, pkt_done, crc_good, crc_bad, ack_req, len_ovf;

  int checks = 0, fails = 0;
  int n_done = 0, n_good = 0, n_bad = 0, n_ack = 0;
  bit fin = 0;

  always #(CLK_NS/2) clk = ~clk;

  pkt_rx_deframer i_pkt_rx_deframer (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
    .mark_hit(mark_hit), .corr_hit(corr_hit), .frame_en(frame_en),
    .auto_ack_en(auto_ack_en), .abort_in(abort_in), .rd_en(rd_en),
    .rd_data(rd_data), .rd_empty(rd_empty), .underflow(underflow),
    .busy(busy), .pkt_done(pkt_done), .crc_good(crc_good), .crc_bad(crc_bad),
    .ack_req(ack_req), .len_ovf(len_ovf)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ b[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_phase = 0, m_len = 0, m_got = 0;
  logic [15:0] m_crc = 0;
  logic [7:0]  m_hi = 0, m_rd = 0;
  logic [7:0]  m_q[$];
  bit m_pm = 0, m_pc = 0, m_under = 0, m_ovf = 0;
  bit m_done = 0, m_good = 0, m_bad = 0, m_ack = 0;

  always @(posedge clk) begin
    bit sop;
    if (rst) begin
      m_phase = 0; m_pm = 0; m_pc = 0; m_under = 0; m_ovf = 0; m_rd = 0;
      m_done = 0; m_good = 0; m_bad = 0; m_ack = 0; m_q.delete();
    end else begin
      sop = frame_en ? (mark_hit && m_pm) : (corr_hit && m_pc);
      m_pm = mark_hit; m_pc = corr_hit;
      m_done = 0; m_good = 0; m_bad = 0; m_ack = 0;
      if (rd_en) begin
        if (m_q.size() > 0) m_rd = m_q.pop_front();
        else m_under = 1;
      end
      if (abort_in) m_phase = 0;
      else if (m_phase == 0) begin
        if (sop) begin m_phase = 1; m_q.delete(); m_crc = 0; m_ovf = 0; end
      end else if (byte_vld) begin
        case (m_phase)
          1: begin
            m_len = byte_in; m_got = 0; m_crc = ref_crc(m_crc, byte_in);
            m_ovf = (m_len > 16); m_phase = (m_len == 0) ? 3 : 2;
          end
          2: begin
            m_crc = ref_crc(m_crc, byte_in);
            if (m_got < 16) m_q.push_back(byte_in);
            m_got++;
            if (m_got == m_len) m_phase = 3;
          end
          3: begin m_hi = byte_in; m_phase = 4; end
          default: begin
            m_done = 1; m_good = ({m_hi, byte_in} == m_crc); m_bad = !m_good;
            m_ack = m_good && auto_ack_en; m_phase = 0;
          end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R3 busy", busy, m_phase != 0);
      check("R3 pkt_done", pkt_done, m_done);
      check("R4 crc_good", crc_good, m_good);
      check("R4 crc_bad", crc_bad, m_bad);
      check("R7 ack_req", ack_req, m_ack);
      check("R6 len_ovf", len_ovf, m_ovf);
      check("R5 rd_empty", rd_empty, m_q.size() == 0);
      check("R5 rd_data", rd_data, m_rd);
      check("R9 underflow", underflow, m_under);
      n_done += pkt_done; n_good += crc_good; n_bad += crc_bad; n_ack += ack_req;
    end
  end

  task automatic send_byte(input logic [7:0] b, input int gap);
    byte_vld = 1; byte_in = b;
    @(negedge clk);
    byte_vld = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic start_pair(input bit use_mark);
    if (use_mark) mark_hit = 1; else corr_hit = 1;
    repeat (2) @(negedge clk);
    mark_hit = 0; corr_hit = 0;
  endtask

  task automatic send_pkt(input int len, input logic [7:0] base, input bit corrupt, input int gap);
    logic [15:0] c;
    c = 16'h0000;
    start_pair(frame_en);
    send_byte(8'(len), gap);
    c = ref_crc(c, 8'(len));
    for (int i = 0; i < len; i++) begin
      send_byte(base + 8'(i), gap);
      c = ref_crc(c, base + 8'(i));
    end
    send_byte(c[15:8], gap);
    send_byte(c[7:0] ^ {7'd0, corrupt}, 0);
    @(negedge clk);
  endtask

  task automatic read_n(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
      check("R5 payload order", rd_data, base + 8'(i));
    end
  endtask

  initial begin
    int d0, a0;
    repeat (3) @(negedge clk);
    check("R10 busy", busy, 0);
    check("R10 rd_empty", rd_empty, 1);
    check("R10 rd_data", rd_data, 0);
    check("R10 underflow", underflow, 0);
    check("R10 pulses", {pkt_done, crc_good, crc_bad, ack_req, len_ovf}, 0);
    rst = 0;
    @(negedge clk);

    // R11: stray bytes while idle
    send_byte(8'h55, 0); send_byte(8'h03, 1);
    check("R11 idle bytes ignored busy", busy, 0);
    check("R11 idle bytes not stored", rd_empty, 1);

    // R1: correlator pairs do nothing in framed mode
    frame_en = 1;
    corr_hit = 1; repeat (3) @(negedge clk); corr_hit = 0;
    check("R1 corr_hit ignored when framed", busy, 0);
    mark_hit = 1; repeat (2) @(negedge clk); mark_hit = 0;
    check("R1 marker pair starts packet", busy, 1);
    abort_in = 1; @(negedge clk); abort_in = 0;
    check("R8 abort to idle", busy, 0);

    // R3/R4/R5: good framed packet
    d0 = n_done;
    send_pkt(5, 8'h10, 0, 0);
    check("R3 one pkt_done", n_done - d0, 1);
    check("R4 good verdict", n_good, 1);
    check("R7 no ack when disabled", n_ack, 0);
    read_n(5, 8'h10);
    check("R5 empty after drain", rd_empty, 1);

    // R7: auto ack on good, none on bad
    auto_ack_en = 1;
    a0 = n_ack;
    send_pkt(3, 8'hA0, 0, 1);
    check("R7 ack on good packet", n_ack - a0, 1);
    send_pkt(4, 8'h33, 1, 0);
    check("R4 bad crc reported", n_bad, 1);
    check("R7 no ack on bad packet", n_ack - a0, 1);
    read_n(4, 8'h33);

    // R2: unframed start, markers ignored
    frame_en = 0;
    mark_hit = 1; repeat (3) @(negedge clk); mark_hit = 0;
    check("R2 mark_hit ignored when unframed", busy, 0);
    send_pkt(16, 8'hC0, 0, 2);
    check("R6 no overflow at 16", len_ovf, 0);
    read_n(16, 8'hC0);

    // R6: length above buffer size
    frame_en = 1;
    d0 = n_good;
    send_pkt(20, 8'h40, 0, 0);
    check("R6 overflow flag", len_ovf, 1);
    check("R6 end found and crc good", n_good - d0, 1);
    read_n(16, 8'h40);
    check("R6 extra bytes dropped", rd_empty, 1);

    // R3: zero length
    d0 = n_good;
    send_pkt(0, 8'h00, 0, 0);
    check("R3 zero length packet good", n_good - d0, 1);
    check("R6 overflow cleared by new start", len_ovf, 0);

    // R8: start events during a packet and abort
    d0 = n_done;
    start_pair(1);
    send_byte(8'd8, 0);
    send_byte(8'h61, 0); send_byte(8'h62, 0);
    mark_hit = 1; repeat (3) @(negedge clk); mark_hit = 0;
    send_byte(8'h63, 0);
    check("R8 restart ignored while busy", busy, 1);
    abort_in = 1; @(negedge clk); abort_in = 0;
    check("R8 abort clears busy", busy, 0);
    repeat (3) @(negedge clk);
    check("R8 no done for aborted packet", n_done - d0, 0);
    read_n(3, 8'h61);

    // R9: empty reads
    rd_en = 1; @(negedge clk); rd_en = 0;
    check("R9 underflow set", underflow, 1);
    check("R9 data held", rd_data, 8'h63);
    repeat (4) @(negedge clk);
    check("R9 underflow sticky", underflow, 1);

    fin = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule